// File: doc/BRIEF.md
# Hash-Steered Packet Channel Dispatcher

This block takes one packet header at a time from a valid/ready stream and picks which of several downstream channels receives the packet. The channel number is the sum of the four bytes of a 32-bit IPv4 address and the two bytes of a 16-bit port, reduced modulo the channel count. Received traffic hashes on the remote source address and port. Transmitted traffic hashes on the remote destination address and port. Broadcast headers skip the hash and always go to channel 0.

Each downstream channel reports through a full flag whether it can take another packet. When the chosen channel can accept the packet, the block issues a one-cycle write strobe on that channel and drives the channel number. When the chosen channel is full, the block drops the packet. Three saturating statistics counters record every header decided, every broadcast header and every packet dropped because its channel was full. A single clear input zeroes all three counters together.

The block has a two-cycle header path. The header is registered on acceptance, and the channel decision is registered one edge later. The ready output stays low for the one cycle while a decision is pending.

Top module: `pkt_dispatch`

## Requirements
- R1: For a receive header (`hdr_is_tx_i`=0, `hdr_bcast_i`=0), the channel is (sum of the four bytes of `hdr_src_ip_i` + the two bytes of `hdr_src_port_i`) mod NUM_CH. That channel's bit of `ch_wr_o` is set and `ch_sel_o` equals its index.
- R2: For a transmit header (`hdr_is_tx_i`=1), the same hash is taken over `hdr_dst_ip_i` and `hdr_dst_port_i`. The source fields have no effect.
- R3: A header with `hdr_bcast_i`=1 is steered to channel 0 whatever its hash, and `cnt_bcast_o` increments by one.
- R4: If the chosen channel's `ch_full_i` bit is 1 in the cycle after acceptance, no strobe is issued and `cnt_drop_o` increments by one. Full flags of other channels have no effect.
- R5: `cnt_rcvd_o` increments by one for every accepted header, whether it is forwarded or dropped.
- R6: While `cnt_clear_i` is 1 at a clock edge, all three counters become 0 after that edge. This takes priority over an increment in the same cycle.
- R7: Each counter saturates at all ones (2^CNT_W-1) instead of wrapping.
- R8: A header is accepted at an edge where `hdr_valid_i` and `hdr_ready_o` are both 1. `hdr_ready_o` is 0 for the following cycle. The strobe on `ch_wr_o` appears after the next edge, lasts exactly one cycle, and has at most one bit set.
- R9: After reset, `hdr_ready_o` is 1, `ch_wr_o` is 0 and all counters are 0.
- R10: The modulo is exact for channel counts that are not a power of two, across the full byte-sum range 0 to 1530.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hdr_valid_i | input | 1 | Header valid |
| hdr_ready_o | output | 1 | Header can be accepted |
| hdr_is_tx_i | input | 1 | 1 = transmit header (hash on destination), 0 = receive header (hash on source) |
| hdr_bcast_i | input | 1 | Broadcast header, steered to channel 0 |
| hdr_src_ip_i | input | 32 | Remote source IPv4 address |
| hdr_src_port_i | input | 16 | Remote source port |
| hdr_dst_ip_i | input | 32 | Remote destination IPv4 address |
| hdr_dst_port_i | input | 16 | Remote destination port |
| ch_full_i | input | NUM_CH | Per-channel full flag |
| cnt_clear_i | input | 1 | Clear all counters |
| ch_sel_o | output | CH_W | Index of the last decided channel |
| ch_wr_o | output | NUM_CH | One-cycle, one-hot write strobe |
| cnt_rcvd_o | output | CNT_W | Headers decided |
| cnt_bcast_o | output | CNT_W | Broadcast headers |
| cnt_drop_o | output | CNT_W | Headers dropped because their channel was full |

## Verification
A corrupted byte sum or a wrong reduction stage shows up as a strobe on the wrong channel two edges after acceptance. The bench uses five channels so that the subtract-based reduction is exercised over many sums, including the extremes. A stuck decision-stage valid would show as ready staying low or as a missing or repeated strobe within the same two cycles. A faulty counter shows on the counter ports one edge after the deciding header. The bench uses four-bit counters so that saturation and clear priority can be reached quickly.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;
  localparam int unsigned MAX_CH = 8;
  localparam int unsigned IP_W   = 32;
  localparam int unsigned PORT_W = 16;
  // six bytes, max 6*255 = 1530
  localparam int unsigned SUM_W  = 11;

  typedef struct packed {
    logic [IP_W-1:0]   ip;
    logic [PORT_W-1:0] port;
  } endpoint_t;
endpackage

// File: rtl/dispatch_hash.sv
module dispatch_hash
  import pkt_dispatch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             is_tx_i,
  input  endpoint_t        src_i,
  input  endpoint_t        dst_i,
  output logic [SUM_W-1:0] sum_o
);
  endpoint_t       sel;
  logic [SUM_W-1:0] sum_d;

  assign sel = is_tx_i ? dst_i : src_i;

  always_comb begin
    sum_d = '0;
    for (int b = 0; b < IP_W / 8; b++)
      sum_d = sum_d + SUM_W'(sel.ip[b*8 +: 8]);
    for (int b = 0; b < PORT_W / 8; b++)
      sum_d = sum_d + SUM_W'(sel.port[b*8 +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (load_i) sum_o <= sum_d;
  end
endmodule

// File: rtl/mod_reduce.sv
module mod_reduce #(
  parameter int unsigned IN_W  = 11,
  parameter int unsigned DIV   = 4,
  parameter int unsigned OUT_W = 2
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] rem_o
);
  localparam bit IS_POW2 = (DIV & (DIV - 1)) == 0;

  generate
    if (DIV <= 1) begin : g_one
      assign rem_o = '0;
    end else if (IS_POW2) begin : g_mask
      assign rem_o = val_i[OUT_W-1:0];
    end else begin : g_sub
      // restoring reduction: subtract DIV<<k when it fits, k high to low
      logic [IN_W-1:0] r [IN_W+1];
      assign r[IN_W] = val_i;
      for (genvar k = IN_W - 1; k >= 0; k--) begin : g_stage
        localparam logic [31:0] SH = 32'(DIV) << k;
        logic [31:0] ext;
        assign ext  = 32'(r[k+1]);
        assign r[k] = (ext >= SH) ? IN_W'(ext - SH) : r[k+1];
      end
      assign rem_o = r[0][OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (inc_i && !(&cnt_o))    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch
  import pkt_dispatch_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  output logic              hdr_ready_o,
  input  logic              hdr_is_tx_i,
  input  logic              hdr_bcast_i,
  input  logic [31:0]       hdr_src_ip_i,
  input  logic [15:0]       hdr_src_port_i,
  input  logic [31:0]       hdr_dst_ip_i,
  input  logic [15:0]       hdr_dst_port_i,
  input  logic [NUM_CH-1:0] ch_full_i,
  input  logic              cnt_clear_i,
  output logic [CH_W-1:0]   ch_sel_o,
  output logic [NUM_CH-1:0] ch_wr_o,
  output logic [CNT_W-1:0]  cnt_rcvd_o,
  output logic [CNT_W-1:0]  cnt_bcast_o,
  output logic [CNT_W-1:0]  cnt_drop_o
);
  localparam int unsigned N_CNT = 3;

  logic             accept;
  logic             s1_valid;
  logic             s1_bcast;
  logic [SUM_W-1:0] s1_sum;
  logic [CH_W-1:0]  hash_ch;
  logic [CH_W-1:0]  chan;
  logic             chan_ok;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];
  endpoint_t        src_ep, dst_ep;

  assign hdr_ready_o = !s1_valid;
  assign accept      = hdr_valid_i && hdr_ready_o;
  assign src_ep      = '{ip: hdr_src_ip_i, port: hdr_src_port_i};
  assign dst_ep      = '{ip: hdr_dst_ip_i, port: hdr_dst_port_i};

  // stage 1: registered byte sum
  dispatch_hash u_hash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .is_tx_i (hdr_is_tx_i),
    .src_i   (src_ep),
    .dst_i   (dst_ep),
    .sum_o   (s1_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_bcast <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) s1_bcast <= hdr_bcast_i;
    end
  end

  mod_reduce #(
    .IN_W  (SUM_W),
    .DIV   (NUM_CH),
    .OUT_W (CH_W)
  ) u_mod (
    .val_i (s1_sum),
    .rem_o (hash_ch)
  );

  // stage 2: decision
  assign chan    = s1_bcast ? '0 : hash_ch;
  assign chan_ok = !ch_full_i[chan];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_wr_o  <= '0;
      ch_sel_o <= '0;
    end else begin
      ch_wr_o <= '0;
      if (s1_valid) begin
        ch_sel_o <= chan;
        if (chan_ok) ch_wr_o <= NUM_CH'(1) << chan;
      end
    end
  end

  assign cnt_inc[0] = s1_valid;
  assign cnt_inc[1] = s1_valid && s1_bcast;
  assign cnt_inc[2] = s1_valid && !chan_ok;

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clear_i),
      .inc_i  (cnt_inc[i]),
      .cnt_o  (cnt_val[i])
    );
  end

  assign cnt_rcvd_o  = cnt_val[0];
  assign cnt_bcast_o = cnt_val[1];
  assign cnt_drop_o  = cnt_val[2];
endmodule

// File: rtl/pkt_dispatch_chk.sv
module pkt_dispatch_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hdr_valid_i,
  input logic              hdr_ready_o,
  input logic              hdr_is_tx_i,
  input logic              hdr_bcast_i,
  input logic [31:0]       hdr_src_ip_i,
  input logic [15:0]       hdr_src_port_i,
  input logic [31:0]       hdr_dst_ip_i,
  input logic [15:0]       hdr_dst_port_i,
  input logic [NUM_CH-1:0] ch_full_i,
  input logic              cnt_clear_i,
  input logic [CH_W-1:0]   ch_sel_o,
  input logic [NUM_CH-1:0] ch_wr_o,
  input logic [CNT_W-1:0]  cnt_rcvd_o,
  input logic [CNT_W-1:0]  cnt_bcast_o,
  input logic [CNT_W-1:0]  cnt_drop_o
);
  // R8
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));

  // R8
  strobe_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_wr_o != '0) |=> (ch_wr_o == '0));

  // R8
  ready_drop_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && hdr_ready_o) |=> !hdr_ready_o);

  // R4
  no_write_to_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_ready_o |=> ((ch_wr_o & $past(ch_full_i)) == '0));

  // R6
  clear_zeroes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clear_i |=> (cnt_rcvd_o == '0 && cnt_bcast_o == '0 && cnt_drop_o == '0));

  // R7
  rcvd_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clear_i |=> (cnt_rcvd_o >= $past(cnt_rcvd_o)));

  // R5
  rcvd_bounds_others_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_bcast_o <= cnt_rcvd_o) && (cnt_drop_o <= cnt_rcvd_o));
endmodule

bind pkt_dispatch pkt_dispatch_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_pkt_dispatch.sv
module sim_pkt_dispatch;
  localparam int unsigned NCH   = 5;
  localparam int unsigned CW    = 4;
  localparam int unsigned SW    = 3;
  localparam time         T_CLK = 10ns;
  localparam int unsigned CMAX  = (1 << CW) - 1;

  logic            clk = 0, rst_n = 0;
  logic            valid = 0, is_tx = 0, bcast = 0, clr = 0;
  logic [31:0]     sip = 0, dip = 0;
  logic [15:0]     sport = 0, dport = 0;
  logic [NCH-1:0]  full = 0;
  logic            ready;
  logic [SW-1:0]   sel;
  logic [NCH-1:0]  wr;
  logic [CW-1:0]   c_rcvd, c_bcast, c_drop;

  int checks = 0, errors = 0;
  int exp_rcvd = 0, exp_bcast = 0, exp_drop = 0;
  int exp_q[$];

  always #(T_CLK/2) clk = ~clk;

  pkt_dispatch #(.NUM_CH(NCH), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(valid), .hdr_ready_o(ready),
    .hdr_is_tx_i(is_tx), .hdr_bcast_i(bcast), .hdr_src_ip_i(sip),
    .hdr_src_port_i(sport), .hdr_dst_ip_i(dip), .hdr_dst_port_i(dport),
    .ch_full_i(full), .cnt_clear_i(clr), .ch_sel_o(sel), .ch_wr_o(wr),
    .cnt_rcvd_o(c_rcvd), .cnt_bcast_o(c_bcast), .cnt_drop_o(c_drop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_hash(input logic [31:0] ip, input logic [15:0] p);
    int s;
    s = int'(ip[7:0]) + int'(ip[15:8]) + int'(ip[23:16]) + int'(ip[31:24])
      + int'(p[7:0]) + int'(p[15:8]);
    return s % NCH;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check_counters(input string tag);
    chk(c_rcvd  == CW'(exp_rcvd),  {tag, " rcvd R5"},  c_rcvd,  exp_rcvd);
    chk(c_bcast == CW'(exp_bcast), {tag, " bcast R3"}, c_bcast, exp_bcast);
    chk(c_drop  == CW'(exp_drop),  {tag, " drop R4"},  c_drop,  exp_drop);
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr != '0) begin
      if (exp_q.size() == 0) begin
        chk(0, "unexpected strobe R4/R8", int'(wr), 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(wr == NCH'(1 << e), "strobe bit R1/R2/R3", int'(wr), 1 << e);
        chk(sel == SW'(e), "channel index R1/R2/R3", int'(sel), e);
      end
    end
  end

  task automatic send(input bit tx, input bit bc, input logic [31:0] s_ip,
                      input logic [15:0] s_p, input logic [31:0] d_ip,
                      input logic [15:0] d_p, input logic [NCH-1:0] fmask,
                      input bit clr_at_decide, input bit do_counters);
    int ch;
    @(negedge clk);
    chk(ready == 1'b1, "ready idle R8", ready, 1);
    valid = 1; is_tx = tx; bcast = bc;
    sip = s_ip; sport = s_p; dip = d_ip; dport = d_p; full = fmask;
    ch = bc ? 0 : (tx ? ref_hash(d_ip, d_p) : ref_hash(s_ip, s_p));
    @(posedge clk);
    #1;
    valid = 0;
    sip = ~sip; dip = ~dip; sport = ~sport; dport = ~dport;
    if (clr_at_decide) clr = 1;
    if (!fmask[ch]) exp_q.push_back(ch);
    exp_rcvd = sat(exp_rcvd + 1);
    if (bc) exp_bcast = sat(exp_bcast + 1);
    if (fmask[ch]) exp_drop = sat(exp_drop + 1);
    if (clr_at_decide) begin exp_rcvd = 0; exp_bcast = 0; exp_drop = 0; end
    @(negedge clk);
    chk(ready == 1'b0, "ready low after accept R8", ready, 0);
    chk(wr == '0, "no early strobe R8", int'(wr), 0);
    @(posedge clk);
    #1;
    clr = 0;
    full = '0;
    @(negedge clk);
    #1;
    chk(exp_q.size() == 0, "strobe issued or dropped R4/R8", exp_q.size(), 0);
    if (do_counters) check_counters("after packet");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(ready == 1'b1, "reset ready R9", ready, 1);
    chk(wr == '0, "reset strobe R9", int'(wr), 0);
    check_counters("reset R9");

    // R1 receive hash on source fields
    send(0, 0, 32'hC0A8_010A, 16'd80, 32'h0, 16'h0, '0, 0, 1);
    send(0, 0, 32'h0A00_0001, 16'h1F90, 32'hFFFF_FFFF, 16'hFFFF, '0, 0, 1);
    // R2 transmit hash on destination fields, source is garbage
    send(1, 0, 32'hDEAD_BEEF, 16'h1234, 32'h0102_0304, 16'h0506, '0, 0, 1);
    send(1, 0, 32'h0, 16'h0, 32'hAC10_0203, 16'h01BB, '0, 0, 1);
    // R3 broadcast with nonzero hash goes to channel 0
    send(0, 1, 32'h0000_0003, 16'h0, 32'h0, 16'h0, '0, 0, 1);
    // R4 chosen channel full -> drop; other full flags ignored
    send(0, 0, 32'h0000_0002, 16'h0, 32'h0, 16'h0, 5'b00100, 0, 1);
    send(0, 0, 32'h0000_0002, 16'h0, 32'h0, 16'h0, 5'b11011, 0, 1);
    send(0, 1, 32'h0000_0001, 16'h0, 32'h0, 16'h0, 5'b00001, 0, 1);
    // R10 extremes of byte sum: 1530 and 1529 and 0
    send(0, 0, 32'hFFFF_FFFF, 16'hFFFF, 32'h0, 16'h0, '0, 0, 1);
    send(0, 0, 32'hFFFF_FFFE, 16'hFFFF, 32'h0, 16'h0, '0, 0, 1);
    send(1, 0, 32'h1, 16'h1, 32'h0, 16'h0, '0, 0, 1);

    // R6 clear pulse
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    exp_rcvd = 0; exp_bcast = 0; exp_drop = 0;
    check_counters("clear R6");

    // R10 sweep of sums across the range, R7 saturation of rcvd
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ip;
      logic [15:0] pt;
      ip = 32'h9E37_79B9 * (i + 1);
      pt = 16'(i * 37 + 11);
      send(i[0], 0, ip, pt, ~ip, ~pt, NCH'(i % 7 == 3 ? 5'b11111 : 5'b0), 0, 0);
    end
    check_counters("saturation R7");

    // R6 clear wins over same-cycle increment
    send(0, 1, 32'h0, 16'h0, 32'h0, 16'h0, 5'b00001, 1, 1);

    // R5 counters resume after clear
    send(0, 0, 32'h0000_0004, 16'h0, 32'h0, 16'h0, '0, 0, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained R8", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule